// File: doc/BRIEF.md
# Multiframe Alignment Proving Detector

This block serves one receive channel of a framed serial line carrying bit-oriented signalling. Once per frame, the upstream frame aligner raises a strobe. With the strobe it presents two bits. One is the multiframe alignment bit for that frame. The other is the signalling data bit. Frame alignment is already done before this block.

The detector looks for a fixed alignment pattern across consecutive frames. One pattern bit belongs to each frame position of the multiframe. The detector first finds a candidate multiframe boundary. It then requires a number of complete multiframes with correct alignment bits before it declares multiframe synchronization. While it is not synchronized, it forwards nothing. Once locked, it forwards every signalling bit as a one-cycle valid pulse.

A locked detector ignores later alignment errors. It leaves lock only when the external red-alarm input rises. On that event it drops the in-sync flag, signals the loss of alignment with a one-cycle pulse, and starts searching again.

Top module: `mfa_proving_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `in_sync`, `sig_valid` and `loa_pulse` are 0.
- R2: In search, the window holds the alignment bits of the last `MF_LEN` strobed frames. Bit i of `PATTERN` belongs to frame i of a multiframe, and frame 0 comes first. When the newest frame completes an exact match, the first proving period is complete. The next strobed frame is then frame 0.
- R3: Lock requires `PROVE_PERIODS` consecutive correct multiframes, with default 3, and the first one is the search match. `in_sync` rises in the cycle after the strobe of the last frame of the final period. It never rises earlier.
- R4: If an alignment bit is wrong during proving, the search restarts with an empty window, and the wrong bit is not kept. A new lock then needs `MF_LEN` new frames that complete a match, plus the remaining full multiframes.
- R5: `sig_valid` is never high unless `in_sync` was high in the previous cycle.
- R6: While locked, each strobe produces `sig_valid` = 1 in the next cycle, with `sig_data` equal to that strobe's `sig_bit`. The first forwarded bit is frame 0 of the multiframe after lock.
- R7: While locked, wrong alignment bits do not affect `in_sync`.
- R8: If `red_alarm` rises (high now, low in the previous cycle) while locked, then in the next cycle `in_sync` is 0 and `loa_pulse` is 1 for exactly one cycle. A strobe in the cycle of the rise is not forwarded, and the search restarts.
- R9: `red_alarm` held high creates no further event. A rise while not locked gives no `loa_pulse`, and it restarts the search and proving from empty.
- R10: Cycles without `frame_stb` change nothing. Their `align_bit` and `sig_bit` are ignored, and they give no `sig_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| align_bit | input | 1 | Multiframe alignment bit of this frame |
| sig_bit | input | 1 | Signalling data bit of this frame |
| red_alarm | input | 1 | External red alarm; a rising edge releases lock |
| sig_data | output | 1 | Forwarded signalling bit |
| sig_valid | output | 1 | One-cycle qualifier for `sig_data` |
| in_sync | output | 1 | Multiframe synchronization flag |
| loa_pulse | output | 1 | One-cycle loss-of-alignment pulse |

## Verification
The bench uses the default build: a 12-frame multiframe, a fixed 12-bit pattern and three proving periods. A lock therefore takes only 36 frames, so each run can repeat several full cycles of search, proving, lock and alarm. The frame gaps vary from back-to-back strobes to idle stretches. The alignment errors are sparse and random, and the alarm toggles at random times. This reaches errors in every proving period and alarms during each state. Fixed-phase sequences pin the exact lock cycle, the restart after a proving miss, and the suppression of a strobe that coincides with an alarm.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

    typedef enum logic [1:0] {
        MFA_SEARCH = 2'd0,
        MFA_PROVE  = 2'd1,
        MFA_LOCK   = 2'd2
    } mfa_state_e;

    typedef struct packed {
        logic stb;
        logic align;
        logic sig;
    } mfa_frame_t;

    function automatic logic rising(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/mfa_red_edge.sv
module mfa_red_edge (
    input  logic clk,
    input  logic rst,
    input  logic red_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= red_i;
    end

    assign rise_o = mfa_pkg::rising(red_i, prev_q);

    // R9: a level held high yields a single event
    assert_single_rise_R9: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/mfa_window.sv
module mfa_window #(
    parameter int                MF_LEN  = 12,
    parameter logic [MF_LEN-1:0] PATTERN = 12'b1101_0011_1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic stb_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int              FW        = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
    localparam logic [FW-1:0]   FILL_FULL = FW'(MF_LEN - 1);

    logic [MF_LEN-1:0] hist_q;
    logic [MF_LEN-1:0] cand;
    logic [FW-1:0]     fill_q;

    assign cand = {bit_i, hist_q[MF_LEN-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (!active_i) begin
            fill_q <= '0;
        end else if (stb_i) begin
            hist_q <= cand;
            if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        end
    end

    assign hit_o = active_i & stb_i & (fill_q == FILL_FULL) & (cand == PATTERN);

    // R4: leaving search empties the window
    assert_window_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (fill_q == '0));

    // R2: fill never passes the window depth
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_FULL);

endmodule

// File: rtl/mfa_prove_fsm.sv
module mfa_prove_fsm
    import mfa_pkg::*;
#(
    parameter int                MF_LEN        = 12,
    parameter logic [MF_LEN-1:0] PATTERN       = 12'b1101_0011_1000,
    parameter int                PROVE_PERIODS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stb_i,
    input  logic       align_i,
    input  logic       hit_i,
    input  logic       red_rise_i,
    output mfa_state_e state_o,
    output logic       loa_o,
    output logic       fwd_o
);
    localparam int            PW       = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
    localparam int            CW       = $clog2(PROVE_PERIODS + 1);
    localparam logic [PW-1:0] PH_LAST  = PW'(MF_LEN - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PROVE_PERIODS - 1);

    mfa_state_e    state_q, state_d;
    logic [PW-1:0] phase_q, phase_d;
    logic [CW-1:0] pcnt_q, pcnt_d;
    logic          loa_q;
    logic          miss;

    assign miss = stb_i & (align_i != PATTERN[phase_q]);

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        pcnt_d  = pcnt_q;
        case (state_q)
            MFA_SEARCH: begin
                if (hit_i) begin
                    phase_d = '0;
                    pcnt_d  = CW'(1);
                    state_d = (PROVE_PERIODS <= 1) ? MFA_LOCK : MFA_PROVE;
                end
            end
            MFA_PROVE: begin
                if (red_rise_i || miss) begin
                    state_d = MFA_SEARCH;
                end else if (stb_i) begin
                    if (phase_q == PH_LAST) begin
                        phase_d = '0;
                        if (pcnt_q == CNT_LAST) state_d = MFA_LOCK;
                        else                    pcnt_d  = pcnt_q + 1'b1;
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
            end
            MFA_LOCK: begin
                if (red_rise_i) state_d = MFA_SEARCH;
            end
            default: state_d = MFA_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MFA_SEARCH;
            phase_q <= '0;
            pcnt_q  <= '0;
            loa_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            pcnt_q  <= pcnt_d;
            loa_q   <= (state_q == MFA_LOCK) & red_rise_i;
        end
    end

    assign state_o = state_q;
    assign loa_o   = loa_q;
    assign fwd_o   = (state_q == MFA_LOCK) & stb_i & ~red_rise_i;

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_LAST);

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == MFA_PROVE) |-> (pcnt_q >= CW'(1) && pcnt_q <= CNT_LAST));

    assert_miss_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == MFA_PROVE && miss) |=> (state_q == MFA_SEARCH));

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == MFA_LOCK && !red_rise_i) |=> (state_q == MFA_LOCK));

    assert_alarm_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == MFA_LOCK && red_rise_i) |=> (state_q == MFA_SEARCH && loa_o));

    assert_loa_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        loa_o |=> !loa_o);

    assert_no_loa_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != MFA_LOCK) |=> !loa_o);

endmodule

// File: rtl/mfa_forward.sv
module mfa_forward (
    input  logic clk,
    input  logic rst,
    input  logic fwd_i,
    input  logic sig_i,
    output logic data_o,
    output logic valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= fwd_i;
            if (fwd_i) data_o <= sig_i;
        end
    end

    // R6: data holds between forwarded bits
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !fwd_i |=> $stable(data_o));

endmodule

// File: rtl/mfa_proving_detector.sv
module mfa_proving_detector
    import mfa_pkg::*;
#(
    parameter int                MF_LEN        = 12,
    parameter logic [MF_LEN-1:0] PATTERN       = 12'b1101_0011_1000,
    parameter int                PROVE_PERIODS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic align_bit,
    input  logic sig_bit,
    input  logic red_alarm,
    output logic sig_data,
    output logic sig_valid,
    output logic in_sync,
    output logic loa_pulse
);
    mfa_frame_t frm;
    mfa_state_e state;
    logic       red_rise;
    logic       hit;
    logic       win_active;
    logic       fwd;

    assign frm        = '{stb: frame_stb, align: align_bit, sig: sig_bit};
    assign win_active = (state == MFA_SEARCH) & ~red_rise;

    mfa_red_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .red_i  (red_alarm),
        .rise_o (red_rise)
    );

    mfa_window #(.MF_LEN(MF_LEN), .PATTERN(PATTERN)) u_window (
        .clk      (clk),
        .rst      (rst),
        .active_i (win_active),
        .stb_i    (frm.stb),
        .bit_i    (frm.align),
        .hit_o    (hit)
    );

    mfa_prove_fsm #(.MF_LEN(MF_LEN), .PATTERN(PATTERN),
                    .PROVE_PERIODS(PROVE_PERIODS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stb_i      (frm.stb),
        .align_i    (frm.align),
        .hit_i      (hit),
        .red_rise_i (red_rise),
        .state_o    (state),
        .loa_o      (loa_pulse),
        .fwd_o      (fwd)
    );

    mfa_forward u_fwd (
        .clk     (clk),
        .rst     (rst),
        .fwd_i   (fwd),
        .sig_i   (frm.sig),
        .data_o  (sig_data),
        .valid_o (sig_valid)
    );

    assign in_sync = (state == MFA_LOCK);

    assert_fwd_needs_sync_R5: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> $past(in_sync));

    assert_valid_from_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> $past(frame_stb));

    assert_lock_on_frame_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(frame_stb));

endmodule

// File: tb/mfa_proving_detector_tb.sv
module mfa_proving_detector_tb;
    localparam int              MFL = 12;
    localparam int              NP  = 3;
    localparam logic [MFL-1:0]  PAT = 12'b1101_0011_1000;

    logic clk = 1'b0;
    logic rst;
    logic frame_stb, align_bit, sig_bit, red_alarm;
    logic sig_data, sig_valid, in_sync, loa_pulse;

    always #5 clk = ~clk;

    mfa_proving_detector #(.MF_LEN(MFL), .PATTERN(PAT), .PROVE_PERIODS(NP)) u_dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .align_bit(align_bit),
        .sig_bit(sig_bit), .red_alarm(red_alarm), .sig_data(sig_data),
        .sig_valid(sig_valid), .in_sync(in_sync), .loa_pulse(loa_pulse)
    );

    int n_checks = 0;
    int n_errors = 0;

    // reference state built from the requirements
    int             m_st;      // 0 search, 1 prove, 2 lock
    logic [MFL-1:0] m_hist;
    int             m_fill, m_phase, m_pcnt;
    logic           m_prev_red;
    logic           e_sync, e_valid, e_data, e_loa;
    logic           red_lvl;
    int             gen_phase;

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic model(input logic stb, input logic al, input logic sg, input logic red);
        logic rise;
        rise       = red & ~m_prev_red;
        m_prev_red = red;
        e_valid    = 1'b0;
        e_loa      = 1'b0;
        case (m_st)
            0: begin
                if (rise) m_fill = 0;
                else if (stb) begin
                    if (m_fill == MFL-1 && {al, m_hist[MFL-1:1]} == PAT) begin
                        m_st = 1; m_phase = 0; m_pcnt = 1; m_fill = 0;
                    end else begin
                        m_hist = {al, m_hist[MFL-1:1]};
                        if (m_fill < MFL-1) m_fill++;
                    end
                end
            end
            1: begin
                if (rise) m_st = 0;
                else if (stb) begin
                    if (al != PAT[m_phase]) m_st = 0;
                    else if (m_phase == MFL-1) begin
                        m_phase = 0;
                        if (m_pcnt == NP-1) m_st = 2;
                        else m_pcnt++;
                    end else m_phase++;
                end
            end
            default: begin
                if (rise) begin m_st = 0; e_loa = 1'b1; end
                else if (stb) begin e_valid = 1'b1; e_data = sg; end
            end
        endcase
        if (m_st != 0) m_fill = 0;
        e_sync = (m_st == 2);
    endtask

    task automatic step(input logic stb, input logic al, input logic sg);
        frame_stb = stb; align_bit = al; sig_bit = sg; red_alarm = red_lvl;
        model(stb, al, sg, red_lvl);
        @(negedge clk);
        chk(in_sync,   e_sync,  "R2/R3/R4/R7 in_sync");
        chk(loa_pulse, e_loa,   "R8/R9 loa_pulse");
        chk(sig_valid, e_valid, "R5/R10 sig_valid");
        if (e_valid) chk(sig_data, e_data, "R6 sig_data");
    endtask

    task automatic frame(input logic err, input int gap, input logic sg);
        step(1'b1, PAT[gen_phase] ^ err, sg);
        gen_phase = (gen_phase + 1) % MFL;
        for (int g = 1; g < gap; g++) step(1'b0, 1'($urandom()), 1'($urandom()));
    endtask

    task automatic frames(input int n, input int gap);
        for (int i = 0; i < n; i++) frame(1'b0, gap, 1'($urandom()));
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; frame_stb = 0; align_bit = 0; sig_bit = 0; red_alarm = 0;
        red_lvl = 1'b0; gen_phase = 0;
        m_st = 0; m_hist = '0; m_fill = 0; m_phase = 0; m_pcnt = 0; m_prev_red = 1'b0;
        e_sync = 0; e_valid = 0; e_data = 0; e_loa = 0;
        repeat (3) @(negedge clk);
        chk(in_sync, 1'b0, "R1 in_sync in reset");
        chk(sig_valid, 1'b0, "R1 sig_valid in reset");
        chk(loa_pulse, 1'b0, "R1 loa_pulse in reset");
        rst = 1'b0;

        // first lock from phase 0
        frames(MFL*NP - 1, 2);
        chk(in_sync, 1'b0, "R3 no lock one frame early");
        frame(1'b0, 2, 1'b0);
        chk(in_sync, 1'b1, "R2 R3 lock after final period");

        // forwarding
        frame(1'b0, 1, 1'b1);
        chk(sig_valid, 1'b1, "R6 first forwarded valid");
        chk(sig_data, 1'b1, "R6 first forwarded data");
        frame(1'b0, 1, 1'b0);
        chk(sig_data, 1'b0, "R6 second forwarded data");
        step(1'b0, 1'b1, 1'b1);
        chk(sig_valid, 1'b0, "R10 no valid without strobe");
        chk(sig_data, 1'b0, "R10 data unchanged without strobe");

        // alignment errors while locked
        for (int i = 0; i < MFL; i++) frame(1'b1, 2, 1'($urandom()));
        chk(in_sync, 1'b1, "R7 lock kept through errors");

        // alarm with a coincident strobe
        red_lvl = 1'b1;
        frame(1'b0, 1, 1'b1);
        chk(in_sync, 1'b0, "R8 sync dropped");
        chk(loa_pulse, 1'b1, "R8 loss pulse");
        chk(sig_valid, 1'b0, "R8 coincident strobe not forwarded");
        step(1'b0, 1'b0, 1'b0);
        chk(loa_pulse, 1'b0, "R8 pulse lasts one cycle");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);
        chk(loa_pulse, 1'b0, "R9 held alarm silent");
        red_lvl = 1'b0;

        // proving miss restarts the search
        while (gen_phase != 0) frame(1'b0, 1, 1'($urandom()));
        frames(MFL + 5, 1);
        frame(1'b1, 1, 1'b0);
        frames(6 + MFL*NP - 1, 1);
        chk(in_sync, 1'b0, "R4 restart needs full proving");
        frame(1'b0, 1, 1'b0);
        chk(in_sync, 1'b1, "R4 lock after restart");

        // random mix
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 59) == 0) red_lvl = ~red_lvl;
            frame(1'($urandom_range(0, 39) == 0), $urandom_range(1, 3), 1'($urandom()));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule